// File: doc/BRIEF.md
# Pulse Dialing Sequencer with Last-Number Redial

This block turns decimal digits, taken one at a time from an upstream digit queue, into loop-disconnect pulse trains on a single line-control output. A low level on that output opens the line loop (break) and a high level closes it (make). For every digit it takes, it samples two things: the tone/pulse selection and the 10/20 pulses-per-second selection. A change to either selection therefore affects only digits taken after the change. In tone mode a digit is consumed without any pulsing, because tone generation sits elsewhere. A mute strobe, active low, covers each pulsed digit from its first break to the end of its inter-digit gap. A busy flag is high whenever the sequencer is not idle.

All timing counts in units. A unit is `UNIT_TICKS` pulses of the `tick_i` strobe from an external divider, nominally 10 ms, so a testbench can run on a scaled time base. Every digit accepted during a call is also written into a 32-entry last-number store. The `new_call_i` strobe empties that store. A one-key redial request made while idle does three things in order. It opens the line for 1.2 s, then holds it closed for 1 s, then replays the stored digits. During replay each digit uses the mode and rate selections current at the moment it is fetched.

Top module: `pulse_dialer`

## Requirements
- R1: After reset `line_o` is 1, `mute_n_o` is 1, `busy_o` is 0, and `fifo_pop_o` is 0 while the queue is empty.
- R2: In pulse mode, a digit code of 1 to 9 produces that many break pulses and code 0 produces ten. Codes 10 to 15 are popped and dropped: they produce no pulses and are not stored.
- R3: At the 10 pps rate, each break lasts 6 units and each make lasts 4 units (60/40 ratio).
- R4: At the 20 pps rate, each break lasts 3 units and each make lasts 2 units.
- R5: After the last make of a pulsed digit, the line stays high for a further 80-unit gap before the sequencer takes another digit. A pulsed digit keeps `busy_o` high for exactly pulses×(break+make)+80 units.
- R6: The rate and tone selections are sampled when a digit is taken. A change made while a digit is in progress applies from the next digit on.
- R7: In tone mode an accepted digit gives no pulse. `line_o` stays 1, `mute_n_o` stays 1 and `busy_o` stays 0, but the digit is still stored for redial.
- R8: `mute_n_o` is 0 exactly during the breaks, makes and gap of a pulsed digit. It is 1 during the redial line break and pause, and whenever the block is idle.
- R9: `fifo_pop_o` is asserted only when the block is idle and no redial request is present. Each pop consumes exactly one digit.
- R10: The store holds the first 32 digits accepted since the last `new_call_i`. A 33rd or later digit is still dialed but is not stored.
- R11: A redial request taken while idle drives `line_o` low for 120 units, then high for a 100-unit pause. It then replays the stored digits in their original order.
- R12: A redial request that arrives while `busy_o` is 1 is dropped and is not remembered for later.
- R13: Timing advances only on `tick_i`. If ticks arrive on every second clock, every duration doubles in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe from the divider |
| fifo_valid_i | input | 1 | The digit queue holds a digit |
| fifo_digit_i | input | 4 | Digit at the head of the queue (0-9 valid) |
| fifo_pop_o | output | 1 | Consume the head digit in this cycle |
| tone_mode_i | input | 1 | 1 = tone mode (no pulsing), 0 = pulse mode |
| rate20_i | input | 1 | 1 = 20 pps, 0 = 10 pps |
| redial_i | input | 1 | One-key redial request |
| new_call_i | input | 1 | Start of a new number; empties the store |
| line_o | output | 1 | Line control: 0 = break, 1 = make |
| mute_n_o | output | 1 | Active-low speech mute |
| busy_o | output | 1 | Sequencer is active |

## Verification
Two situations are the hardest to reach from the ports. The first is the store's full boundary, where a 33rd digit must be dialed but not recorded. Pulse-dialing 33 digits would take thousands of cycles, so the bench accepts 33 digits in tone mode, which consumes one per cycle. It then replays them in pulse mode and counts the digits and the pulses per digit. The second is a rate change in the middle of a digit. The bench queues two digits and, in a parallel thread, flips the rate selection partway through the first digit's pulse train. It then compares the break widths before and after the digit boundary.

// File: rtl/pdial_pkg.sv
package pdial_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RBRK,
        ST_RPAUSE,
        ST_FETCH,
        ST_BRK,
        ST_MAKE,
        ST_GAP
    } dial_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // number of loop breaks for a decimal digit code
    function automatic logic [3:0] pulses_of(input logic [3:0] code);
        return (code == 4'd0) ? 4'd10 : code;
    endfunction

endpackage

// File: rtl/pdial_timer.sv
module pdial_timer #(
    parameter int UNIT_TICKS = 1,
    parameter int DW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          load_i,
    input  logic [DW-1:0] dur_i,
    output logic          done_o
);
    localparam int PW = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [DW-1:0] cnt;
    } tmr_t;

    tmr_t d, q;
    logic unit_end;

    assign unit_end = tick_i && (q.pre == PW'(UNIT_TICKS - 1));
    assign done_o   = unit_end && (q.cnt == DW'(1));

    always_comb begin
        d = q;
        if (load_i) begin
            d.pre = '0;
            d.cnt = dur_i;
        end else if (tick_i && (q.cnt != '0)) begin
            if (unit_end) begin
                d.pre = '0;
                d.cnt = q.cnt - DW'(1);
            end else begin
                d.pre = q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/pdial_store.sv
module pdial_store #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int CW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          wr_i,
    input  logic [3:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [3:0]    rdata_o,
    output logic [CW-1:0] len_o
);
    logic [3:0]       mem [DEPTH];
    logic [CW-1:0]    len_d, len_q, base;
    logic [DEPTH-1:0] we;

    assign base = clr_i ? '0 : len_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_we
        assign we[g] = wr_i && (base == CW'(g));
    end

    always_comb begin
        len_d = base;
        if (wr_i && (base < CW'(DEPTH))) len_d = base + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (we[i]) mem[i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];
    assign len_o   = len_q;

endmodule

// File: rtl/pulse_dialer.sv
module pulse_dialer
    import pdial_pkg::*;
#(
    parameter int UNIT_TICKS = 1,
    parameter int DEPTH      = 32,
    parameter int BRK_SLOW   = 6,
    parameter int MAKE_SLOW  = 4,
    parameter int BRK_FAST   = 3,
    parameter int MAKE_FAST  = 2,
    parameter int GAP_U      = 80,
    parameter int RD_BREAK   = 120,
    parameter int RD_PAUSE   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       fifo_valid_i,
    input  logic [3:0] fifo_digit_i,
    output logic       fifo_pop_o,
    input  logic       tone_mode_i,
    input  logic       rate20_i,
    input  logic       redial_i,
    input  logic       new_call_i,
    output logic       line_o,
    output logic       mute_n_o,
    output logic       busy_o
);
    localparam int MAXD = max2(max2(max2(RD_BREAK, RD_PAUSE), max2(GAP_U, BRK_SLOW)),
                               max2(max2(MAKE_SLOW, BRK_FAST), MAKE_FAST));
    localparam int DW   = $clog2(MAXD + 1);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW   = $clog2(DEPTH + 1);

    typedef struct packed {
        dial_st_e      st;
        logic [3:0]    left;
        logic          fast;
        logic          replay;
        logic [CW-1:0] idx;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, left: 4'd0, fast: 1'b0, replay: 1'b0, idx: '0};

    ctl_t d, q;

    logic          t_load, t_done, pop, s_wr;
    logic [DW-1:0] t_dur;
    logic [3:0]    s_rdata;
    logic [CW-1:0] s_len;

    function automatic logic [DW-1:0] brk_len(input logic f);
        return f ? DW'(BRK_FAST) : DW'(BRK_SLOW);
    endfunction

    function automatic logic [DW-1:0] mk_len(input logic f);
        return f ? DW'(MAKE_FAST) : DW'(MAKE_SLOW);
    endfunction

    pdial_timer #(.UNIT_TICKS(UNIT_TICKS), .DW(DW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .load_i (t_load),
        .dur_i  (t_dur),
        .done_o (t_done)
    );

    pdial_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (new_call_i && !q.replay),
        .wr_i    (s_wr),
        .wdata_i (fifo_digit_i),
        .raddr_i (q.idx[AW-1:0]),
        .rdata_o (s_rdata),
        .len_o   (s_len)
    );

    always_comb begin
        d      = q;
        t_load = 1'b0;
        t_dur  = '0;
        pop    = 1'b0;
        s_wr   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (redial_i) begin
                    d.st     = ST_RBRK;
                    d.replay = 1'b1;
                    d.idx    = '0;
                    t_load   = 1'b1;
                    t_dur    = DW'(RD_BREAK);
                end else if (fifo_valid_i) begin
                    pop = 1'b1;
                    if (fifo_digit_i < 4'd10) begin
                        s_wr = 1'b1;
                        if (!tone_mode_i) begin
                            d.st   = ST_BRK;
                            d.left = pulses_of(fifo_digit_i);
                            d.fast = rate20_i;
                            t_load = 1'b1;
                            t_dur  = brk_len(rate20_i);
                        end
                    end
                end
            end
            ST_RBRK: begin
                if (t_done) begin
                    d.st   = ST_RPAUSE;
                    t_load = 1'b1;
                    t_dur  = DW'(RD_PAUSE);
                end
            end
            ST_RPAUSE: begin
                if (t_done) d.st = ST_FETCH;
            end
            ST_FETCH: begin
                if (q.idx == s_len) begin
                    d.st     = ST_IDLE;
                    d.replay = 1'b0;
                end else begin
                    d.idx = q.idx + CW'(1);
                    if (!tone_mode_i) begin
                        d.st   = ST_BRK;
                        d.left = pulses_of(s_rdata);
                        d.fast = rate20_i;
                        t_load = 1'b1;
                        t_dur  = brk_len(rate20_i);
                    end
                end
            end
            ST_BRK: begin
                if (t_done) begin
                    d.st   = ST_MAKE;
                    t_load = 1'b1;
                    t_dur  = mk_len(q.fast);
                end
            end
            ST_MAKE: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (q.left == 4'd1) begin
                        d.st  = ST_GAP;
                        t_dur = DW'(GAP_U);
                    end else begin
                        d.st   = ST_BRK;
                        d.left = q.left - 4'd1;
                        t_dur  = brk_len(q.fast);
                    end
                end
            end
            ST_GAP: begin
                if (t_done) d.st = q.replay ? ST_FETCH : ST_IDLE;
            end
            default: d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign fifo_pop_o = pop;
    assign line_o     = !((q.st == ST_BRK) || (q.st == ST_RBRK));
    assign mute_n_o   = !((q.st == ST_BRK) || (q.st == ST_MAKE) || (q.st == ST_GAP));
    assign busy_o     = (q.st != ST_IDLE);

endmodule

// File: rtl/pulse_dialer_chk.sv
module pulse_dialer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fifo_digit_valid,
    input logic [3:0] fifo_digit,
    input logic       fifo_pop,
    input logic       tone_mode,
    input logic       redial,
    input logic       line,
    input logic       mute_n,
    input logic       busy
);
    assert_line_low_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !line |-> busy);

    assert_mute_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |-> busy);

    assert_pop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (fifo_digit_valid && !busy && !redial));

    assert_tone_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && tone_mode) |=> (line && mute_n && !busy));

    assert_bad_code_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !tone_mode && (fifo_digit > 4'd9)) |=> (!busy && line));

    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !tone_mode && (fifo_digit < 4'd10)) |=> (!line && !mute_n));

    assert_redial_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && redial) |=> (!line && mute_n && busy));

endmodule

bind pulse_dialer pulse_dialer_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fifo_digit_valid (fifo_valid_i),
    .fifo_digit       (fifo_digit_i),
    .fifo_pop         (fifo_pop_o),
    .tone_mode        (tone_mode_i),
    .redial           (redial_i),
    .line             (line_o),
    .mute_n           (mute_n_o),
    .busy             (busy_o)
);

// File: tb/pulse_dialer_test.sv
module pulse_dialer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       fifo_valid_i;
    logic [3:0] fifo_digit_i;
    logic       fifo_pop_o;
    logic       tone_mode_i = 1'b0;
    logic       rate20_i = 1'b0;
    logic       redial_i = 1'b0;
    logic       new_call_i = 1'b0;
    logic       line_o, mute_n_o, busy_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pulse_dialer uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .fifo_valid_i (fifo_valid_i),
        .fifo_digit_i (fifo_digit_i),
        .fifo_pop_o   (fifo_pop_o),
        .tone_mode_i  (tone_mode_i),
        .rate20_i     (rate20_i),
        .redial_i     (redial_i),
        .new_call_i   (new_call_i),
        .line_o       (line_o),
        .mute_n_o     (mute_n_o),
        .busy_o       (busy_o)
    );

    // tick source
    int tick_div = 1;
    int tph = 0;
    always @(negedge clk) begin
        tph    = (tph + 1 >= tick_div) ? 0 : tph + 1;
        tick_i = (tph == 0);
    end

    // digit queue model
    logic [3:0] qd [256];
    int head = 0;
    int tail = 0;
    assign fifo_valid_i = (head < tail);
    assign fifo_digit_i = qd[head[7:0]];
    always @(posedge clk) if (fifo_valid_i && fifo_pop_o) head <= head + 1;

    task automatic push(input logic [3:0] dg);
        qd[tail[7:0]] = dg;
        tail++;
    endtask

    // observation record
    int lo_len [512];
    int hi_len [512];
    int n_lo, n_hi, mute_on, busy_cyc, pop_busy;
    int dp [64];
    int nd;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic capture(input int maxcyc);
        int  cur, idle;
        bit  prev, seen;
        n_lo = 0; n_hi = 0; mute_on = 0; busy_cyc = 0; pop_busy = 0;
        cur = 0; idle = 0; prev = 1'b1; seen = 1'b0;
        for (int c = 0; c < maxcyc; c++) begin
            @(negedge clk);
            if (c == 0) begin
                redial_i   = 1'b0;
                new_call_i = 1'b0;
            end
            if (line_o !== prev) begin
                if (!prev) begin
                    if (n_lo < 512) lo_len[n_lo] = cur;
                    n_lo++;
                end else if (seen) begin
                    if (n_hi < 512) hi_len[n_hi] = cur;
                    n_hi++;
                end
                if (!line_o) seen = 1'b1;
                cur  = 1;
                prev = line_o;
            end else begin
                cur++;
            end
            if (!mute_n_o) mute_on++;
            if (busy_o) busy_cyc++;
            if (fifo_pop_o && busy_o) pop_busy++;
            if (!busy_o && line_o) idle++;
            else idle = 0;
            if (idle >= 6) break;
        end
    endtask

    task automatic group(input int s);
        nd = 0;
        for (int i = s; i < n_lo; i++) begin
            if (i == s || hi_len[i-1] > 30) begin
                dp[nd] = 0;
                nd++;
            end
            dp[nd-1]++;
        end
    endtask

    task automatic t_reset;
        check(line_o === 1'b1, "R1 line", int'(line_o), 1);
        check(mute_n_o === 1'b1, "R1 mute", int'(mute_n_o), 1);
        check(busy_o === 1'b0, "R1 busy", int'(busy_o), 0);
        check(fifo_pop_o === 1'b0, "R1 pop", int'(fifo_pop_o), 0);
    endtask

    task automatic t_slow_digit;
        rate20_i = 1'b0;
        push(4'd3);
        capture(400);
        group(0);
        check(nd == 1 && dp[0] == 3, "R2 pulses for 3", dp[0], 3);
        for (int i = 0; i < 3; i++) check(lo_len[i] == 6, "R3 break", lo_len[i], 6);
        check(hi_len[0] == 4 && hi_len[1] == 4, "R3 make", hi_len[0], 4);
        check(busy_cyc == 110, "R5 busy span", busy_cyc, 110);
        check(mute_on == busy_cyc, "R8 mute span", mute_on, busy_cyc);
    endtask

    task automatic t_zero_fast;
        rate20_i = 1'b1;
        push(4'd0);
        capture(400);
        group(0);
        check(nd == 1 && dp[0] == 10, "R2 pulses for 0", dp[0], 10);
        check(lo_len[0] == 3 && lo_len[9] == 3, "R4 break", lo_len[9], 3);
        check(hi_len[0] == 2 && hi_len[8] == 2, "R4 make", hi_len[8], 2);
        check(busy_cyc == 130, "R5 busy span fast", busy_cyc, 130);
        rate20_i = 1'b0;
    endtask

    task automatic t_invalid;
        push(4'd13);
        capture(50);
        check(n_lo == 0, "R2 bad code pulses", n_lo, 0);
        check(busy_cyc == 0, "R2 bad code busy", busy_cyc, 0);
        check(fifo_valid_i == 1'b0, "R9 bad code consumed", int'(fifo_valid_i), 0);
    endtask

    task automatic t_two_digits;
        push(4'd2);
        push(4'd1);
        capture(600);
        group(0);
        check(nd == 2 && dp[0] == 2 && dp[1] == 1, "R9 one digit per pop", nd, 2);
        check(hi_len[1] >= 84 && hi_len[1] <= 86, "R5 gap", hi_len[1], 85);
        check(pop_busy == 0, "R9 no pop while busy", pop_busy, 0);
    endtask

    task automatic t_mode_mid;
        rate20_i = 1'b0;
        push(4'd3);
        push(4'd2);
        fork
            capture(800);
            begin
                repeat (10) @(negedge clk);
                rate20_i = 1'b1;
            end
        join
        check(n_lo == 5, "R6 pulse total", n_lo, 5);
        check(lo_len[2] == 6, "R6 digit in progress keeps rate", lo_len[2], 6);
        check(lo_len[3] == 3 && lo_len[4] == 3, "R6 next digit new rate", lo_len[3], 3);
        rate20_i = 1'b0;
    endtask

    task automatic t_tone;
        tone_mode_i = 1'b1;
        push(4'd5);
        capture(50);
        check(n_lo == 0, "R7 no pulses", n_lo, 0);
        check(mute_on == 0, "R7 no mute", mute_on, 0);
        check(busy_cyc == 0, "R7 not busy", busy_cyc, 0);
        check(fifo_valid_i == 1'b0, "R7 digit consumed", int'(fifo_valid_i), 0);
        tone_mode_i = 1'b0;
    endtask

    task automatic t_tick_half;
        tick_div = 2;
        push(4'd1);
        capture(600);
        check(n_lo == 1, "R13 pulse count", n_lo, 1);
        check(lo_len[0] >= 11 && lo_len[0] <= 13, "R13 break doubled", lo_len[0], 12);
        tick_div = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_redial;
        @(negedge clk);
        new_call_i = 1'b1;
        @(negedge clk);
        new_call_i = 1'b0;
        push(4'd4);
        push(4'd13);
        push(4'd1);
        capture(1000);
        group(0);
        check(nd == 2, "R2 dialed digits", nd, 2);
        tone_mode_i = 1'b1;
        push(4'd6);
        repeat (10) @(negedge clk);
        tone_mode_i = 1'b0;
        redial_i = 1'b1;
        capture(2000);
        check(lo_len[0] == 120, "R11 redial break", lo_len[0], 120);
        check(hi_len[0] >= 100 && hi_len[0] <= 102, "R11 redial pause", hi_len[0], 101);
        group(1);
        check(nd == 3, "R10 stored count after new call", nd, 3);
        check(dp[0] == 4 && dp[1] == 1, "R11 replay order", dp[0] * 10 + dp[1], 41);
        check(dp[2] == 6, "R7 tone digit stored", dp[2], 6);
        check(busy_cyc - mute_on >= 221 && busy_cyc - mute_on <= 226,
              "R8 mute released in redial break", busy_cyc - mute_on, 224);
    endtask

    task automatic t_redial_busy;
        push(4'd2);
        fork
            capture(600);
            begin
                repeat (8) @(negedge clk);
                redial_i = 1'b1;
                @(negedge clk);
                redial_i = 1'b0;
            end
        join
        check(n_lo == 2, "R12 only digit pulses", n_lo, 2);
        check(lo_len[0] == 6 && lo_len[1] == 6, "R12 no redial break", lo_len[0], 6);
        check(busy_o == 1'b0, "R12 request not kept", int'(busy_o), 0);
    endtask

    task automatic t_overflow;
        @(negedge clk);
        new_call_i = 1'b1;
        @(negedge clk);
        new_call_i = 1'b0;
        tone_mode_i = 1'b1;
        for (int k = 0; k < 31; k++) push(4'd1);
        push(4'd2);
        push(4'd5);
        repeat (45) @(negedge clk);
        tone_mode_i = 1'b0;
        redial_i = 1'b1;
        capture(8000);
        group(1);
        check(nd == 32, "R10 stored digits at full", nd, 32);
        check(dp[31] == 2, "R10 last stored digit", dp[31], 2);
        check(n_lo == 34, "R10 33rd digit dropped", n_lo, 34);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_slow_digit();
        t_zero_fast();
        t_invalid();
        t_two_digits();
        t_mode_mid();
        t_tone();
        t_tick_half();
        t_redial();
        t_redial_busy();
        t_overflow();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule